// File: doc/BRIEF.md
# Shared Parallel Bus Phase Sequencer

This block is the bus controller of one node on a shared parallel peripheral bus that holds at most eight nodes. Each node has a fixed ID from 0 to 7. A local host hands the block a request that names a peer ID. The request asks either to select a target as initiator, or to reconnect to an initiator by reselection as a target that earlier let go of the bus. The block then steps the bus through its phases. After reset it waits for the bus to go idle and contends for the bus on a modelled wired-OR ID bus. When it wins, it drives the selection (or reselection) handshake and then follows the information phases that the connected peer presents.

The bus is modelled with separate drive and sense signals. A node drives `bsy_o`, `sel_o`, `io_o` and `id_bus_o`. The system ORs the outputs of all nodes and feeds the result back on the `*_i` inputs. During the information phases the peer drives a 2-bit phase code. The block reports its current phase as a 3-bit code. It also gives a one-cycle win pulse, and it marks the end of each connection with a one-cycle pulse that says whether the transfer completed or the peer disconnected to finish its work later. A missing reply to selection ends in a timeout.

Top module: `bus_phase_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, at each clock edge the block enters phase code 0 (reset), with `bsy_o`, `sel_o`, `io_o`, `id_bus_o` and every pulse output low.
- R2: On the first clock edge with `rst` low, phase code 0 gives way to phase code 1 (bus free).
- R3: With a request pending in phase 1, the block enters phase code 2 (arbitration) only after it has sampled `bsy_i` and `sel_i` both low on two consecutive edges while in phase 1. Entry happens on the second of those edges.
- R4: Arbitration lasts exactly ARB_CYCLES cycles. Throughout it, `bsy_o` is high and `id_bus_o` carries only the node's own ID bit (bit OWN_ID).
- R5: At the end of the window the block checks `id_bus_i`. If any bit above OWN_ID is set, it loses, returns to phase 1 and keeps the request, which it tries again after the next idle bus.
- R6: Otherwise it wins. `won_pulse_o` is high for one cycle, and the phase becomes 3 (selection) for an initiator request or 4 (reselection) for a reconnect request.
- R7: In phases 3 and 4, `sel_o` is high, `bsy_o` is low and `id_bus_o` holds the own ID bit plus the peer ID bit. `io_o` is high in phase 4 only.
- R8: Sampling `bsy_i` high in phase 3 or 4 starts the information phases. On each cycle that `bsy_i` stays high, the phase follows `info_code_i`: 0 (command) gives 5, 1 (data) gives 6, 2 (status) and 3 (message) give 7.
- R9: When `bsy_i` is sampled low in an information phase, the block returns to phase 1. It raises `done_o` for one cycle if a status code was seen during the connection, and otherwise raises `disc_o` for one cycle (disconnect).
- R10: If no `bsy_i` reply arrives within SEL_TIMEOUT cycles of phase 3 or 4, the block returns to phase 1 and raises `sel_timeout_o`.
- R11: `host_start` is accepted only in phase 1 while no request is pending. At any other time it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_start | input | 1 | Host request strobe |
| host_resel | input | 1 | 1 = reconnect by reselection, 0 = select as initiator |
| host_peer_id | input | ID_W | ID of the peer node |
| bsy_i | input | 1 | Sensed wired-OR busy line |
| sel_i | input | 1 | Sensed wired-OR select line |
| id_bus_i | input | NODE_COUNT | Sensed wired-OR ID bus |
| info_code_i | input | 2 | Information phase code presented by the peer |
| bsy_o | output | 1 | Busy drive |
| sel_o | output | 1 | Select drive |
| io_o | output | 1 | Direction drive, high during reselection |
| id_bus_o | output | NODE_COUNT | ID bus drive |
| phase_o | output | 3 | Current phase code |
| won_pulse_o | output | 1 | One-cycle arbitration win |
| done_o | output | 1 | One-cycle connection completed |
| disc_o | output | 1 | One-cycle connection ended by disconnect |
| sel_timeout_o | output | 1 | Selection timeout flag |

## Verification
On every cycle the assertions check the local contracts: what the block drives during arbitration and selection, that it enters arbitration only after an idle bus, that wins and losses agree with the ID bus sampled one cycle earlier, and that the end-of-connection and timeout pulses come only from the proper phases. Only the bench scenarios can show whole phase sequences. These are a loss to a higher ID followed by a retry, a win over a lower ID, a disconnect followed by reselection, the exact lengths of the arbitration window and the timeout, and a host request that is ignored in the middle of a connection.

// File: rtl/bps_pkg.sv
package bps_pkg;

   typedef enum logic [2:0] {
      PH_RESET   = 3'd0,
      PH_FREE    = 3'd1,
      PH_ARB     = 3'd2,
      PH_SEL     = 3'd3,
      PH_RESEL   = 3'd4,
      PH_CMD     = 3'd5,
      PH_DATA    = 3'd6,
      PH_STATMSG = 3'd7
   } phase_t;

   localparam logic [1:0] INFO_CMD    = 2'd0;
   localparam logic [1:0] INFO_DATA   = 2'd1;
   localparam logic [1:0] INFO_STATUS = 2'd2;
   localparam logic [1:0] INFO_MSG    = 2'd3;

   function automatic phase_t info_to_phase(input logic [1:0] code);
      case (code)
         INFO_CMD:  return PH_CMD;
         INFO_DATA: return PH_DATA;
         default:   return PH_STATMSG;
      endcase
   endfunction

endpackage

// File: rtl/bps_arbiter.sv
module bps_arbiter #(
   parameter int NODE_COUNT = 8,
   parameter int OWN_ID     = 0,
   parameter int ARB_CYCLES = 4
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  active,
   input  logic [NODE_COUNT-1:0] id_bus_i,
   output logic                  window_end,
   output logic                  lost
);
   localparam int CW = $clog2(ARB_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(ARB_CYCLES - 1);

   logic [CW-1:0]         cnt_q;
   logic [NODE_COUNT-1:0] higher_mask;

   for (genvar i = 0; i < NODE_COUNT; i++) begin : g_mask
      assign higher_mask[i] = (i > OWN_ID);
   end

   always_ff @(posedge clk) begin
      if (rst || !active) cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign window_end = active && (cnt_q == LAST);
   assign lost       = |(id_bus_i & higher_mask);
endmodule

// File: rtl/bps_sel_timer.sv
module bps_sel_timer #(
   parameter int SEL_TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic active,
   output logic expired
);
   localparam int TW = $clog2(SEL_TIMEOUT + 1);
   localparam logic [TW-1:0] LAST = TW'(SEL_TIMEOUT - 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !active) cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign expired = active && (cnt_q == LAST);
endmodule

// File: rtl/bps_info_tracker.sv
module bps_info_tracker
   import bps_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       clear,
   input  logic       sample,
   input  logic [1:0] code,
   output logic       status_seen
);
   always_ff @(posedge clk) begin
      if (rst || clear) status_seen <= 1'b0;
      else if (sample && code == INFO_STATUS) status_seen <= 1'b1;
   end
endmodule

// File: rtl/bps_flag_gen.sv
module bps_flag_gen #(
   parameter bit STICKY = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clear,
   output logic flag
);
   if (STICKY) begin : g_sticky
      always_ff @(posedge clk) begin
         if (rst || clear) flag <= 1'b0;
         else if (set) flag <= 1'b1;
      end
   end else begin : g_pulse
      logic unused_clear;
      assign unused_clear = clear;
      always_ff @(posedge clk) begin
         if (rst) flag <= 1'b0;
         else flag <= set;
      end
   end
endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
   import bps_pkg::*;
#(
   parameter int NODE_COUNT     = 8,
   parameter int OWN_ID         = 7,
   parameter int ARB_CYCLES     = 4,
   parameter int SEL_TIMEOUT    = 16,
   parameter bit STICKY_TIMEOUT = 1'b0,
   localparam int ID_W = (NODE_COUNT > 1) ? $clog2(NODE_COUNT) : 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  host_start,
   input  logic                  host_resel,
   input  logic [ID_W-1:0]       host_peer_id,
   input  logic                  bsy_i,
   input  logic                  sel_i,
   input  logic [NODE_COUNT-1:0] id_bus_i,
   input  logic [1:0]            info_code_i,
   output logic                  bsy_o,
   output logic                  sel_o,
   output logic                  io_o,
   output logic [NODE_COUNT-1:0] id_bus_o,
   output logic [2:0]            phase_o,
   output logic                  won_pulse_o,
   output logic                  done_o,
   output logic                  disc_o,
   output logic                  sel_timeout_o
);
   if (NODE_COUNT < 2 || NODE_COUNT > 8) begin : g_bad_count
      $error("NODE_COUNT must lie in 2..8");
   end
   if (OWN_ID < 0 || OWN_ID >= NODE_COUNT) begin : g_bad_id
      $error("OWN_ID must be below NODE_COUNT");
   end
   if (ARB_CYCLES < 1) begin : g_bad_arb
      $error("ARB_CYCLES must be at least 1");
   end
   if (SEL_TIMEOUT < 1) begin : g_bad_tmo
      $error("SEL_TIMEOUT must be at least 1");
   end

   localparam logic [NODE_COUNT-1:0] OWN_BIT = NODE_COUNT'(1) << OWN_ID;

   phase_t            phase_q, phase_d;
   logic              pending_q, resel_q, free_seen_q;
   logic [ID_W-1:0]   peer_q;
   logic              won_d, done_d, disc_d, tmo_d;
   logic              won_q, done_q, disc_q;
   logic              accept, bus_idle, in_select, in_info;
   logic              arb_end, arb_lost, sel_expired, status_seen;
   logic [NODE_COUNT-1:0] peer_bit;

   assign bus_idle  = !bsy_i && !sel_i;
   assign in_select = (phase_q == PH_SEL) || (phase_q == PH_RESEL);
   assign in_info   = (phase_q == PH_CMD) || (phase_q == PH_DATA) ||
                      (phase_q == PH_STATMSG);
   assign accept    = host_start && (phase_q == PH_FREE) && !pending_q;
   assign peer_bit  = NODE_COUNT'(1) << peer_q;

   bps_arbiter #(
      .NODE_COUNT(NODE_COUNT),
      .OWN_ID    (OWN_ID),
      .ARB_CYCLES(ARB_CYCLES)
   ) u_arb (
      .clk       (clk),
      .rst       (rst),
      .active    (phase_q == PH_ARB),
      .id_bus_i  (id_bus_i),
      .window_end(arb_end),
      .lost      (arb_lost)
   );

   bps_sel_timer #(
      .SEL_TIMEOUT(SEL_TIMEOUT)
   ) u_tmr (
      .clk    (clk),
      .rst    (rst),
      .active (in_select),
      .expired(sel_expired)
   );

   bps_info_tracker u_trk (
      .clk        (clk),
      .rst        (rst),
      .clear      (phase_q == PH_ARB),
      .sample     ((in_select || in_info) && bsy_i),
      .code       (info_code_i),
      .status_seen(status_seen)
   );

   bps_flag_gen #(
      .STICKY(STICKY_TIMEOUT)
   ) u_tflag (
      .clk  (clk),
      .rst  (rst),
      .set  (tmo_d),
      .clear(accept),
      .flag (sel_timeout_o)
   );

   always_comb begin
      phase_d = phase_q;
      won_d   = 1'b0;
      done_d  = 1'b0;
      disc_d  = 1'b0;
      tmo_d   = 1'b0;
      unique case (phase_q)
         PH_RESET: phase_d = PH_FREE;
         PH_FREE: begin
            if (pending_q && free_seen_q && bus_idle) phase_d = PH_ARB;
         end
         PH_ARB: begin
            if (arb_end) begin
               if (arb_lost) begin
                  phase_d = PH_FREE;
               end else begin
                  won_d   = 1'b1;
                  phase_d = resel_q ? PH_RESEL : PH_SEL;
               end
            end
         end
         PH_SEL, PH_RESEL: begin
            if (bsy_i) begin
               phase_d = info_to_phase(info_code_i);
            end else if (sel_expired) begin
               phase_d = PH_FREE;
               tmo_d   = 1'b1;
            end
         end
         default: begin
            if (bsy_i) begin
               phase_d = info_to_phase(info_code_i);
            end else begin
               phase_d = PH_FREE;
               done_d  = status_seen;
               disc_d  = !status_seen;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q     <= PH_RESET;
         pending_q   <= 1'b0;
         resel_q     <= 1'b0;
         peer_q      <= '0;
         free_seen_q <= 1'b0;
         won_q       <= 1'b0;
         done_q      <= 1'b0;
         disc_q      <= 1'b0;
      end else begin
         phase_q     <= phase_d;
         free_seen_q <= (phase_q == PH_FREE) && bus_idle;
         won_q       <= won_d;
         done_q      <= done_d;
         disc_q      <= disc_d;
         if (accept) begin
            pending_q <= 1'b1;
            resel_q   <= host_resel;
            peer_q    <= host_peer_id;
         end else if (won_d) begin
            pending_q <= 1'b0;
         end
      end
   end

   always_comb begin
      id_bus_o = '0;
      if (phase_q == PH_ARB) id_bus_o = OWN_BIT;
      else if (in_select)    id_bus_o = OWN_BIT | peer_bit;
   end

   assign bsy_o       = (phase_q == PH_ARB);
   assign sel_o       = in_select;
   assign io_o        = (phase_q == PH_RESEL);
   assign phase_o     = phase_q;
   assign won_pulse_o = won_q;
   assign done_o      = done_q;
   assign disc_o      = disc_q;
endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
   parameter int NODE_COUNT = 8,
   parameter int OWN_ID     = 7
) (
   input logic                  clk,
   input logic                  rst,
   input logic [2:0]            phase_o,
   input logic                  bsy_o,
   input logic                  sel_o,
   input logic                  io_o,
   input logic [NODE_COUNT-1:0] id_bus_o,
   input logic [NODE_COUNT-1:0] id_bus_i,
   input logic                  bsy_i,
   input logic                  sel_i,
   input logic                  won_pulse_o,
   input logic                  done_o,
   input logic                  disc_o,
   input logic                  sel_timeout_o
);
   function automatic logic [NODE_COUNT-1:0] above_own();
      logic [NODE_COUNT-1:0] m;
      m = '0;
      for (int i = 0; i < NODE_COUNT; i++) m[i] = (i > OWN_ID);
      return m;
   endfunction

   localparam logic [NODE_COUNT-1:0] HI = above_own();

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (phase_o == 3'd0 && !bsy_o && !sel_o && id_bus_o == '0)); // R1

   AST_RESET_EXIT: assert property (@(posedge clk) disable iff (rst)
      ($past(phase_o) == 3'd0) |-> (phase_o inside {3'd0, 3'd1})); // R2

   AST_ARB_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
      (phase_o == 3'd2 && $past(phase_o) == 3'd1) |-> $past(!bsy_i && !sel_i)); // R3

   AST_ARB_DRIVE: assert property (@(posedge clk) disable iff (rst)
      bsy_o |-> ($onehot(id_bus_o) && id_bus_o[OWN_ID] && !sel_o)); // R4

   AST_LOSE_HIGHER: assert property (@(posedge clk) disable iff (rst)
      (phase_o == 3'd1 && $past(phase_o) == 3'd2) |-> ($past(id_bus_i & HI) != '0)); // R5

   AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (rst)
      won_pulse_o |-> ($past(phase_o) == 3'd2 && $past(id_bus_i & HI) == '0 && sel_o)); // R6

   AST_SEL_DRIVE: assert property (@(posedge clk) disable iff (rst)
      sel_o |-> (!bsy_o && id_bus_o[OWN_ID] && $countones(id_bus_o) <= 2)); // R7

   AST_IO_IN_SEL: assert property (@(posedge clk) disable iff (rst)
      io_o |-> sel_o); // R7

   AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
      (done_o || disc_o) |-> (!(done_o && disc_o) && phase_o == 3'd1 && $past(phase_o) >= 3'd5)); // R9

   AST_TIMEOUT_SRC: assert property (@(posedge clk) disable iff (rst)
      $rose(sel_timeout_o) |-> ($past(phase_o) inside {3'd3, 3'd4} && phase_o == 3'd1)); // R10
endmodule

bind bus_phase_seq bps_checker #(
   .NODE_COUNT(NODE_COUNT),
   .OWN_ID    (OWN_ID)
) u_bps_chk (
   .clk          (clk),
   .rst          (rst),
   .phase_o      (phase_o),
   .bsy_o        (bsy_o),
   .sel_o        (sel_o),
   .io_o         (io_o),
   .id_bus_o     (id_bus_o),
   .id_bus_i     (id_bus_i),
   .bsy_i        (bsy_i),
   .sel_i        (sel_i),
   .won_pulse_o  (won_pulse_o),
   .done_o       (done_o),
   .disc_o       (disc_o),
   .sel_timeout_o(sel_timeout_o)
);

// File: tb/tb_bus_phase_seq.sv
module tb_bus_phase_seq;
   localparam int N    = 8;
   localparam int OWN  = 5;
   localparam int ARBC = 4;
   localparam int TMO  = 16;
   localparam logic [N-1:0] OWN_BIT = N'(1) << OWN;

   localparam int K_PH = 1, K_WON = 2, K_DONE = 3, K_DISC = 4, K_TMO = 5;

   typedef struct {
      int    kind;
      int    val;
      string req;
   } ev_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic host_start = 1'b0, host_resel = 1'b0;
   logic [2:0] host_peer_id = '0;
   logic others_bsy = 1'b0, tgt_bsy = 1'b0;
   logic [N-1:0] others_id = '0;
   logic [1:0] info_code = '0;
   logic bsy_i, sel_i;
   logic [N-1:0] id_bus_i;
   logic bsy_o, sel_o, io_o, won_pulse_o, done_o, disc_o, sel_timeout_o;
   logic [N-1:0] id_bus_o;
   logic [2:0] phase_o;

   int checks = 0, errors = 0;
   ev_t exp_q[$];
   logic [2:0] prev_phase = 3'd0;
   int arb_len = 0;
   bit arb_ok = 1'b1;

   always #10 clk = ~clk;

   assign bsy_i    = bsy_o | others_bsy | tgt_bsy;
   assign sel_i    = sel_o;
   assign id_bus_i = id_bus_o | others_id;

   bus_phase_seq #(
      .NODE_COUNT (N),
      .OWN_ID     (OWN),
      .ARB_CYCLES (ARBC),
      .SEL_TIMEOUT(TMO)
   ) dut (
      .clk(clk), .rst(rst), .host_start(host_start), .host_resel(host_resel),
      .host_peer_id(host_peer_id), .bsy_i(bsy_i), .sel_i(sel_i),
      .id_bus_i(id_bus_i), .info_code_i(info_code), .bsy_o(bsy_o),
      .sel_o(sel_o), .io_o(io_o), .id_bus_o(id_bus_o), .phase_o(phase_o),
      .won_pulse_o(won_pulse_o), .done_o(done_o), .disc_o(disc_o),
      .sel_timeout_o(sel_timeout_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic expect_ev(input int kind, input int val, input string req);
      ev_t e;
      e.kind = kind; e.val = val; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic observe(input int kind, input int val);
      ev_t e;
      if (exp_q.size() == 0) begin
         check(1'b0, "R11 unexpected event", kind * 16 + val, 0);
      end else begin
         e = exp_q.pop_front();
         check(e.kind == kind && e.val == val, e.req, kind * 16 + val, e.kind * 16 + e.val);
      end
   endtask

   // Monitor: scoreboard consumer plus arbitration window check (R4)
   always @(negedge clk) begin
      if (rst) begin
         prev_phase = phase_o;
      end else begin
         if (phase_o == 3'd2) begin
            arb_len++;
            if (!(bsy_o && id_bus_o == OWN_BIT)) arb_ok = 1'b0;
         end else if (prev_phase == 3'd2) begin
            check(arb_len == ARBC && arb_ok, "R4 window", arb_len, ARBC);
            arb_len = 0;
            arb_ok  = 1'b1;
         end
         if (phase_o != prev_phase) observe(K_PH, int'(phase_o));
         if (won_pulse_o)   observe(K_WON, 0);
         if (done_o)        observe(K_DONE, 0);
         if (disc_o)        observe(K_DISC, 0);
         if (sel_timeout_o) observe(K_TMO, 0);
         prev_phase = phase_o;
      end
   end

   task automatic host_req(input bit resel, input int peer);
      @(negedge clk);
      host_start = 1'b1; host_resel = resel; host_peer_id = 3'(peer);
      @(negedge clk);
      host_start = 1'b0;
   endtask

   task automatic wait_phase(input int p);
      while (int'(phase_o) != p) @(negedge clk);
   endtask

   task automatic target_serve(input int n, input logic [7:0] codes, input bit exp_io,
                               input int peer, input bit poke);
      while (!sel_o) @(negedge clk);
      check(id_bus_o == (OWN_BIT | (N'(1) << peer)), "R7 ids", id_bus_o, OWN_BIT | (N'(1) << peer));
      check(io_o == exp_io && !bsy_o, "R7 io/bsy", {io_o, bsy_o}, {exp_io, 1'b0});
      for (int i = 0; i < n; i++) begin
         tgt_bsy = 1'b1;
         info_code = codes[2*i +: 2];
         if (poke && i == 1) host_start = 1'b1;
         @(negedge clk);
         host_start = 1'b0;
         @(negedge clk);
         @(negedge clk);
      end
      tgt_bsy = 1'b0;
      info_code = 2'd0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(20 * 200000);
      check(1'b0, "R8 watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : driver
      // R1 reset state
      repeat (3) @(negedge clk);
      check(phase_o == 3'd0 && !bsy_o && !sel_o && !io_o && id_bus_o == '0 &&
            !won_pulse_o && !done_o && !disc_o && !sel_timeout_o, "R1 reset", phase_o, 0);
      // R2 first edge after reset release
      expect_ev(K_PH, 1, "R2");
      rst = 1'b0;
      @(negedge clk);
      check(phase_o == 3'd1, "R2 free after reset", phase_o, 1);
      repeat (3) @(negedge clk);

      // plain selection: command, data, status, message -> done (R6 R8 R9)
      expect_ev(K_PH, 2, "R3"); expect_ev(K_PH, 3, "R6"); expect_ev(K_WON, 0, "R6");
      expect_ev(K_PH, 5, "R8"); expect_ev(K_PH, 6, "R8"); expect_ev(K_PH, 7, "R8");
      expect_ev(K_PH, 1, "R9"); expect_ev(K_DONE, 0, "R9");
      host_req(1'b0, 3);
      target_serve(4, {2'd3, 2'd2, 2'd1, 2'd0}, 1'b0, 3, 1'b0);
      repeat (4) @(negedge clk);

      // higher contender ID 6: lose, retry after idle (R5)
      expect_ev(K_PH, 2, "R3"); expect_ev(K_PH, 1, "R5 lose");
      expect_ev(K_PH, 2, "R5 retry"); expect_ev(K_PH, 3, "R6"); expect_ev(K_WON, 0, "R6");
      expect_ev(K_PH, 5, "R8"); expect_ev(K_PH, 7, "R8");
      expect_ev(K_PH, 1, "R9"); expect_ev(K_DONE, 0, "R9");
      host_req(1'b0, 3);
      wait_phase(2);
      others_id = N'(1) << 6; others_bsy = 1'b1;
      wait_phase(1);
      repeat (10) @(negedge clk);
      check(phase_o == 3'd1, "R5 holds while busy", phase_o, 1);
      others_id = '0; others_bsy = 1'b0;
      target_serve(2, {4'd0, 2'd2, 2'd0}, 1'b0, 3, 1'b0);
      repeat (4) @(negedge clk);

      // lower contender ID 2: win; host_start mid-connection ignored (R11)
      expect_ev(K_PH, 2, "R3"); expect_ev(K_PH, 3, "R6 win over lower"); expect_ev(K_WON, 0, "R6");
      expect_ev(K_PH, 5, "R8"); expect_ev(K_PH, 6, "R8"); expect_ev(K_PH, 7, "R8");
      expect_ev(K_PH, 1, "R9"); expect_ev(K_DONE, 0, "R9");
      host_req(1'b0, 3);
      wait_phase(2);
      others_id = N'(1) << 2; others_bsy = 1'b1;
      wait_phase(3);
      others_id = '0; others_bsy = 1'b0;
      target_serve(3, {2'd0, 2'd2, 2'd1, 2'd0}, 1'b0, 3, 1'b1);
      repeat (20) @(negedge clk);
      check(phase_o == 3'd1 && !bsy_o, "R11 start ignored", phase_o, 1);

      // selection timeout (R10)
      expect_ev(K_PH, 2, "R3"); expect_ev(K_PH, 3, "R6"); expect_ev(K_WON, 0, "R6");
      expect_ev(K_PH, 1, "R10"); expect_ev(K_TMO, 0, "R10");
      host_req(1'b0, 1);
      wait_phase(3);
      begin
         int cnt = 0;
         while (phase_o == 3'd3) begin
            cnt++;
            @(negedge clk);
         end
         check(cnt == TMO, "R10 timeout length", cnt, TMO);
      end
      repeat (4) @(negedge clk);

      // disconnect, then reconnect by reselection (R9 R7)
      expect_ev(K_PH, 2, "R3"); expect_ev(K_PH, 3, "R6"); expect_ev(K_WON, 0, "R6");
      expect_ev(K_PH, 5, "R8"); expect_ev(K_PH, 7, "R8 message");
      expect_ev(K_PH, 1, "R9"); expect_ev(K_DISC, 0, "R9 disconnect");
      host_req(1'b0, 3);
      target_serve(2, {4'd0, 2'd3, 2'd0}, 1'b0, 3, 1'b0);
      repeat (6) @(negedge clk);
      expect_ev(K_PH, 2, "R3"); expect_ev(K_PH, 4, "R6 reselection"); expect_ev(K_WON, 0, "R6");
      expect_ev(K_PH, 6, "R8"); expect_ev(K_PH, 7, "R8");
      expect_ev(K_PH, 1, "R9"); expect_ev(K_DONE, 0, "R9");
      host_req(1'b1, 3);
      target_serve(3, {2'd0, 2'd3, 2'd2, 2'd1}, 1'b1, 3, 1'b0);
      repeat (4) @(negedge clk);

      // arbitration only after two idle samples (R3)
      others_bsy = 1'b1;
      host_req(1'b0, 3);
      repeat (20) @(negedge clk);
      check(phase_o == 3'd1, "R3 no arbitration while busy", phase_o, 1);
      expect_ev(K_PH, 2, "R3"); expect_ev(K_PH, 3, "R6"); expect_ev(K_WON, 0, "R6");
      expect_ev(K_PH, 5, "R8"); expect_ev(K_PH, 7, "R8");
      expect_ev(K_PH, 1, "R9"); expect_ev(K_DONE, 0, "R9");
      others_bsy = 1'b0;
      @(negedge clk);
      check(phase_o == 3'd1, "R3 first idle sample", phase_o, 1);
      @(negedge clk);
      check(phase_o == 3'd2, "R3 entry on second idle sample", phase_o, 2);
      target_serve(2, {4'd0, 2'd2, 2'd0}, 1'b0, 3, 1'b0);
      repeat (6) @(negedge clk);

      check(exp_q.size() == 0, "R9 all expected events seen", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule